// File: doc/BRIEF.md
# Nested Delay Counter

This block produces a programmable delay from two nested down-counters. A start pulse captures an outer count and an inner count. The inner counter steps down once per clock. Each time it runs out it is refilled with the captured inner value, and the outer counter steps down once. When the outer counter runs out, the block drops busy and raises a one-cycle done pulse. The total delay in clock cycles is the product of the two counts.

Each step decrements first and tests second. A count loaded as zero therefore wraps to all ones and runs the full range of the counter rather than ending at once. The zero test on each counter combines two half-width OR reductions, one over the upper half and one over the lower half. A counter reads as zero only when both halves are clear.

Start pulses that arrive while a delay is running are dropped. A new delay can be started in the same cycle that done is high.

Top module: `nested_delay_counter`

## Requirements
- R1: While reset is high, and in the first cycle after reset, busy and done are both 0.
- R2: The widths of the outer and inner counts are set by the parameters OUTER_W and INNER_W, both 16 by default.
- R3: A start seen at a clock edge while the block is idle captures both count inputs, and busy is 1 from the following cycle.
- R4: With nonzero loads O and I, busy stays 1 for exactly O*I cycles.
- R5: On every outer pass the inner counter restarts from the captured inner value, so the passes after the first are as long as the first.
- R6: An inner load of 0 counts as 2^INNER_W cycles per outer pass, because the decrement comes before the test.
- R7: An outer load of 0 counts as 2^OUTER_W outer passes, for the same reason.
- R8: done is 1 for exactly one cycle. That cycle is the first one in which busy is 0 after a delay, and done is 0 in every other cycle.
- R9: While busy is 1, a start pulse and any change on the count inputs have no effect: the running delay keeps its length.
- R10: A counter exits only when both its upper and lower halves are zero. A value with a clear lower half and a set upper half keeps counting.
- R11: A start given in the cycle in which done is 1 is accepted and begins a new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled at each clock edge |
| outer_count | input | OUTER_W | Outer loop count; 0 means 2^OUTER_W |
| inner_count | input | INNER_W | Inner loop count; 0 means 2^INNER_W |
| busy | output | 1 | High while a delay is running |
| done | output | 1 | One-cycle pulse when the delay ends |

## Verification
The bench builds the block with OUTER_W=4 and INNER_W=5. These narrow widths put the wrap-on-zero loads, including the 512-cycle all-zero case, and the largest loads within a short run. The odd inner width gives halves of 3 and 2 bits, so the inner loads 4 and 8 have a clear lower half and a set upper half, which exercises the two-half zero test. The narrow widths also keep the retrigger, mid-run reset and back-to-back start cases cheap enough to time cycle by cycle.

// File: rtl/ndc_pkg.sv
package ndc_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } ndc_state_e;

endpackage

// File: rtl/ndc_zero_detect.sv
// Zero test built from two half-width OR reductions (R10).
module ndc_zero_detect #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  localparam int LO_W = W / 2;
  localparam int HI_W = W - LO_W;

  logic [HI_W-1:0] hi_part;
  logic [LO_W-1:0] lo_part;
  logic            hi_any;
  logic            lo_any;

  assign hi_part = val[W-1:LO_W];
  assign lo_part = val[LO_W-1:0];
  assign hi_any  = |hi_part;
  assign lo_any  = |lo_part;
  assign is_zero = ~(hi_any | lo_any);

endmodule

// File: rtl/ndc_down_counter.sv
// Decrement-then-test counter; the reload register is generated only when needed.
module ndc_down_counter #(
  parameter int W          = 16,
  parameter bit HAS_RELOAD = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         wrap
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_q;
  logic [W-1:0] dec_val;
  logic [W-1:0] reload_val;

  assign dec_val = cnt_q - ONE;

  ndc_zero_detect #(.W(W)) u_zero (
    .val     (dec_val),
    .is_zero (wrap)
  );

  generate
    if (HAS_RELOAD) begin : g_reload
      logic [W-1:0] init_q;
      always_ff @(posedge clk) begin
        if (rst)       init_q <= '0;
        else if (load) init_q <= load_val;
      end
      assign reload_val = init_q;
    end else begin : g_no_reload
      assign reload_val = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= wrap ? reload_val : dec_val;
  end

endmodule

// File: rtl/ndc_sequencer.sv
module ndc_sequencer
  import ndc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic inner_wrap,
  input  logic outer_wrap,
  output logic load,
  output logic inner_dec,
  output logic outer_dec,
  output logic busy,
  output logic done
);
  ndc_state_e state_q;
  logic       running;
  logic       finish;

  assign running   = (state_q == ST_RUN);
  assign load      = start & ~running;
  assign inner_dec = running;
  assign outer_dec = running & inner_wrap;
  assign finish    = outer_dec & outer_wrap;
  assign busy      = running;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      done    <= 1'b0;
    end else begin
      done <= finish;
      case (state_q)
        ST_IDLE: if (start)  state_q <= ST_RUN;
        ST_RUN:  if (finish) state_q <= ST_IDLE;
        default:             state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/nested_delay_counter.sv
module nested_delay_counter #(
  parameter int OUTER_W = 16,
  parameter int INNER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [OUTER_W-1:0] outer_count,
  input  logic [INNER_W-1:0] inner_count,
  output logic               busy,
  output logic               done
);
  logic load;
  logic inner_dec;
  logic outer_dec;
  logic inner_wrap;
  logic outer_wrap;

  ndc_sequencer u_seq (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .inner_wrap (inner_wrap),
    .outer_wrap (outer_wrap),
    .load       (load),
    .inner_dec  (inner_dec),
    .outer_dec  (outer_dec),
    .busy       (busy),
    .done       (done)
  );

  ndc_down_counter #(.W(INNER_W), .HAS_RELOAD(1'b1)) u_inner (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (inner_count),
    .dec      (inner_dec),
    .wrap     (inner_wrap)
  );

  ndc_down_counter #(.W(OUTER_W), .HAS_RELOAD(1'b0)) u_outer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (outer_count),
    .dec      (outer_dec),
    .wrap     (outer_wrap)
  );

endmodule

// File: rtl/ndc_checker.sv
module ndc_checker (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!busy && !done));

  p_busy_needs_start_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));

  p_busy_ends_with_done_r4: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done));

  p_done_after_busy_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  p_done_single_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_retrigger_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done));

endmodule

bind nested_delay_counter ndc_checker u_chk (
  .clk   (clk),
  .rst   (rst),
  .start (start),
  .busy  (busy),
  .done  (done)
);

// File: tb/nested_delay_counter_tb.sv
module nested_delay_counter_tb;
  localparam int OW = 4;
  localparam int IW = 5;
  localparam int NVEC = 8;
  localparam int LIMIT = 2000;

  // stimulus: outer, inner, expected busy cycles
  localparam int VEC_O[NVEC]   = '{1, 3, 2, 1,  0, 0, 15, 4};
  localparam int VEC_I[NVEC]   = '{1, 5, 4, 0,  1, 0, 31, 8};
  localparam int VEC_EXP[NVEC] = '{1, 15, 8, 32, 16, 512, 465, 32};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [OW-1:0] outer_count = '0;
  logic [IW-1:0] inner_count = '0;
  logic          busy;
  logic          done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  nested_delay_counter #(.OUTER_W(OW), .INNER_W(IW)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .outer_count (outer_count),
    .inner_count (inner_count),
    .busy        (busy),
    .done        (done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic apply_start(input int o, input int i);
    start = 1'b1;
    outer_count = OW'(o);
    inner_count = IW'(i);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Counts busy cycles from the negedge after the start edge; ends at the negedge where busy is low.
  task automatic measure(input int exp, input string tag, input int inject_at);
    int cnt = 0;
    while (busy && cnt < LIMIT) begin
      cnt++;
      if (cnt == inject_at) begin
        start = 1'b1;
        outer_count = OW'(1);
        inner_count = IW'(1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0;
    check(cnt == exp, tag, cnt, exp);
    check(done == 1'b1, "R8 done high when busy drops", int'(done), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 idle during reset", int'({busy, done}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 idle after reset", int'({busy, done}), 0);

    // table walk: R2 R4 R5 R6 R7 R10
    for (int v = 0; v < NVEC; v++) begin
      apply_start(VEC_O[v], VEC_I[v]);
      check(busy == 1'b1, "R3 busy after start", int'(busy), 1);
      measure(VEC_EXP[v], $sformatf("R4/R5/R6/R7/R10 vector %0d length", v), 0);
      @(negedge clk);
      check(done == 1'b0, "R8 done single cycle", int'(done), 0);
      repeat (2) @(negedge clk);
    end

    // R9: start pulse and new count inputs during a run are ignored
    apply_start(3, 4);
    measure(12, "R9 retrigger ignored length", 5);
    @(negedge clk);
    check(busy == 1'b0, "R9 no second run", int'(busy), 0);
    repeat (2) @(negedge clk);

    // R11: start in the done cycle
    apply_start(2, 3);
    measure(6, "R11 first run length", 0);
    apply_start(1, 7);
    check(busy == 1'b1, "R11 start in done cycle accepted", int'(busy), 1);
    measure(7, "R11 second run length", 0);
    @(negedge clk);

    // R1: reset in the middle of a run
    apply_start(5, 5);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(busy == 1'b0 && done == 1'b0, "R1 mid-run reset clears", int'({busy, done}), 0);
    @(negedge clk);
    check(busy == 1'b0 && done == 1'b0, "R1 stays idle after reset", int'({busy, done}), 0);

    // R10 on inner alone: inner 8 has zero lower half
    apply_start(1, 8);
    measure(8, "R10 upper half keeps counting", 0);

    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule